// File: doc/BRIEF.md
# Secondary Column Slot Generator

This block sits behind a memory controller's column command issue path and decides what goes into the secondary column-control slot that belongs to each column command. A write with at least one disabled byte gets a mask packet. That packet has its mask-present bit set and carries the 16 byte enables as two 8-bit fields, one per data byte lane group. A write that enables all 16 bytes, and every read, gets an extended packet instead, with the mask-present bit clear. Because that extended slot is otherwise unused, it carries a pending precharge request when one is waiting, and a no-operation code when none is.

The secondary slot follows its column command by a configurable number of cycles. Column commands enter on a valid/ready stream. `cmd_ready` is high whenever the requested delay matches the delay in use. When software changes `cfg_delay`, `cmd_ready` drops and stays low until every slot already in flight has been emitted. The new delay then takes effect and `cmd_ready` rises again. While `cmd_ready` is low, the command on the inputs must be held. Precharge requests use a plain level request with a single-cycle acknowledge. The slot outputs are a timed strobe with no back-pressure, because the slot position on the channel is fixed.

Top module: `col_mask_slot_gen`

## Requirements
- R1: After reset, `slot_valid` is 0 and `cmd_ready` is 1, and the delay in use is 1.
- R2: An accepted write whose `cmd_be` is not all ones produces a slot with `slot_is_mask`=1 and `slot_mbit`=1, and this includes the all-zeros case.
- R3: In a mask slot, `slot_mask_a` equals `cmd_be[7:0]` (lane A bytes) and `slot_mask_b` equals `cmd_be[15:8]` (lane B bytes). A bit value of 1 means the byte is written and 0 means it is kept.
- R4: An accepted write with `cmd_be`=16'hFFFF produces an extended slot: `slot_is_mask`=0, `slot_mbit`=0, and both mask fields are 0.
- R5: An accepted read always produces an extended slot, whatever its `cmd_be`.
- R6: In an extended slot, if `pre_req` is 1, then `slot_xop`=2'b01 (precharge), `slot_xbank`=`pre_bank`, and `pre_ack` is 1 for that cycle. In a mask slot, `pre_ack` stays 0.
- R7: In an extended slot, if `pre_req` is 0, then `slot_xop`=2'b00 (no-op) and `slot_xbank`=0.
- R8: A command accepted at a clock edge produces its slot during the D-th cycle after that edge, where D is the delay in use. A `cfg_delay` of 0 is treated as 1, and values above MAX_DLY are treated as MAX_DLY.
- R9: When the clamped `cfg_delay` differs from the delay in use, `cmd_ready` is 0. The new delay is adopted only once no slot is in flight.
- R10: `slot_valid` is 0 in every cycle that has no accepted command due.
- R11: Commands accepted on consecutive cycles produce slots on consecutive cycles, in order of acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_delay | input | DLY_W | Requested command-to-slot delay in cycles |
| cmd_valid | input | 1 | Column command present |
| cmd_ready | output | 1 | Command accepted this cycle if valid |
| cmd_is_write | input | 1 | 1 = write, 0 = read |
| cmd_be | input | 16 | Byte enables, 1 = write byte |
| pre_req | input | 1 | Precharge waiting for a free slot |
| pre_bank | input | BANK_W | Bank of the waiting precharge |
| pre_ack | output | 1 | Precharge placed in this cycle's slot |
| slot_valid | output | 1 | Secondary slot emitted this cycle |
| slot_is_mask | output | 1 | 1 = mask packet, 0 = extended packet |
| slot_mbit | output | 1 | Mask-present bit of the packet |
| slot_mask_a | output | 8 | Lane A byte mask |
| slot_mask_b | output | 8 | Lane B byte mask |
| slot_xop | output | 2 | Extended op: 00 no-op, 01 precharge |
| slot_xbank | output | BANK_W | Bank for the extended op |

## Verification
The bench drives writes with all-ones, all-zeros, single-hole and random enables. A design that tested for "any byte enabled" instead of "all bytes enabled" would misclassify these, and a swap of the two lane fields would show up in the random masks. Reads are sent with partial enables and with a precharge pending, which exposes a design that masks reads or lets a mask slot consume the precharge. The bench changes the delay while a command is in flight, and it also sets it to 0 and above the maximum. A design that adopts the new delay early, fails to clamp, or mistimes the tap would emit slots in the wrong cycle or emit stray ones.

// File: rtl/col_slot_pkg.sv
package col_slot_pkg;
  localparam int BE_W   = 16;
  localparam int LANE_W = BE_W / 2;

  typedef enum logic [1:0] {
    XOP_NOP = 2'b00,
    XOP_PRE = 2'b01
  } xop_e;

  typedef struct packed {
    logic              partial;
    logic [LANE_W-1:0] mask_a;
    logic [LANE_W-1:0] mask_b;
  } slot_item_t;
endpackage

// File: rtl/col_slot_classify.sv
module col_slot_classify
  import col_slot_pkg::*;
(
  input  logic            is_write,
  input  logic [BE_W-1:0] be,
  output slot_item_t      item
);
  logic all_on;

  always_comb begin
    all_on = &be;
    item = '0;
    if (is_write && !all_on) begin
      item.partial = 1'b1;
      item.mask_a  = be[LANE_W-1:0];
      item.mask_b  = be[BE_W-1:LANE_W];
    end
  end
endmodule

// File: rtl/col_slot_delay_line.sv
module col_slot_delay_line
  import col_slot_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  slot_item_t       in_item,
  input  logic [DLY_W-1:0] sel,
  output logic             out_valid,
  output slot_item_t       out_item,
  output logic             empty
);
  logic [DEPTH-1:0] vld;
  slot_item_t       stage [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rst_n) vld[0] <= 1'b0;
        else        vld[0] <= in_valid;
        stage[0] <= in_item;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (!rst_n) vld[i] <= 1'b0;
        else        vld[i] <= vld[i-1];
        stage[i] <= stage[i-1];
      end
    end
  end

  always_comb begin
    out_valid = 1'b0;
    out_item  = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (sel == DLY_W'(i + 1)) begin
        out_valid = vld[i];
        out_item  = stage[i];
      end
    end
  end

  assign empty = ~|vld;

  AST_EMPTY_NO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !out_valid); // R10
endmodule

// File: rtl/col_mask_slot_gen.sv
module col_mask_slot_gen
  import col_slot_pkg::*;
#(
  parameter int MAX_DLY = 8,
  parameter int DLY_W   = 4,
  parameter int BANK_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DLY_W-1:0]  cfg_delay,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_is_write,
  input  logic [BE_W-1:0]   cmd_be,
  input  logic              pre_req,
  input  logic [BANK_W-1:0] pre_bank,
  output logic              pre_ack,
  output logic              slot_valid,
  output logic              slot_is_mask,
  output logic              slot_mbit,
  output logic [LANE_W-1:0] slot_mask_a,
  output logic [LANE_W-1:0] slot_mask_b,
  output logic [1:0]        slot_xop,
  output logic [BANK_W-1:0] slot_xbank
);
  localparam logic [DLY_W-1:0] DLY_MAX = DLY_W'(MAX_DLY);
  localparam logic [DLY_W-1:0] DLY_ONE = DLY_W'(1);

  logic [DLY_W-1:0] want_dly, active_dly;
  logic             accept, pipe_empty, tap_valid;
  slot_item_t       new_item, tap_item;

  always_comb begin
    if (cfg_delay == '0)          want_dly = DLY_ONE;
    else if (cfg_delay > DLY_MAX) want_dly = DLY_MAX;
    else                          want_dly = cfg_delay;
  end

  assign cmd_ready = (want_dly == active_dly);
  assign accept    = cmd_valid && cmd_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)                                active_dly <= DLY_ONE;
    else if (!cmd_ready && pipe_empty)         active_dly <= want_dly;
  end

  col_slot_classify u_classify (
    .is_write (cmd_is_write),
    .be       (cmd_be),
    .item     (new_item)
  );

  col_slot_delay_line #(.DEPTH(MAX_DLY), .DLY_W(DLY_W)) u_line (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (accept),
    .in_item   (new_item),
    .sel       (active_dly),
    .out_valid (tap_valid),
    .out_item  (tap_item),
    .empty     (pipe_empty)
  );

  always_comb begin
    slot_valid   = tap_valid;
    slot_is_mask = 1'b0;
    slot_mbit    = 1'b0;
    slot_mask_a  = '0;
    slot_mask_b  = '0;
    slot_xop     = XOP_NOP;
    slot_xbank   = '0;
    pre_ack      = 1'b0;
    if (tap_valid) begin
      if (tap_item.partial) begin
        slot_is_mask = 1'b1;
        slot_mbit    = 1'b1;
        slot_mask_a  = tap_item.mask_a;
        slot_mask_b  = tap_item.mask_b;
      end else if (pre_req) begin
        slot_xop   = XOP_PRE;
        slot_xbank = pre_bank;
        pre_ack    = 1'b1;
      end
    end
  end

  AST_MASK_NOT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_valid && slot_is_mask) |-> !(&{slot_mask_b, slot_mask_a})); // R2
  AST_EXT_MASKS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_valid && !slot_is_mask) |-> (slot_mask_a == '0 && slot_mask_b == '0)); // R4
  AST_ACK_ONLY_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    pre_ack |-> (slot_valid && !slot_is_mask && pre_req)); // R6
  AST_UNIT_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && active_dly == DLY_ONE) |=> slot_valid); // R8
  AST_SWITCH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(active_dly) |-> !slot_valid); // R9
endmodule

// File: tb/test_col_mask_slot_gen.sv
module test_col_mask_slot_gen;
  localparam int MAX_DLY = 8;
  localparam int DLY_W   = 4;
  localparam int BANK_W  = 5;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [DLY_W-1:0]  cfg_delay;
  logic              cmd_valid, cmd_ready, cmd_is_write;
  logic [15:0]       cmd_be;
  logic              pre_req, pre_ack;
  logic [BANK_W-1:0] pre_bank;
  logic              slot_valid, slot_is_mask, slot_mbit;
  logic [7:0]        slot_mask_a, slot_mask_b;
  logic [1:0]        slot_xop;
  logic [BANK_W-1:0] slot_xbank;

  always #5 clk = ~clk;

  col_mask_slot_gen #(.MAX_DLY(MAX_DLY), .DLY_W(DLY_W), .BANK_W(BANK_W)) i_col_mask_slot_gen (
    .clk(clk), .rst_n(rst_n), .cfg_delay(cfg_delay),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_is_write(cmd_is_write),
    .cmd_be(cmd_be), .pre_req(pre_req), .pre_bank(pre_bank), .pre_ack(pre_ack),
    .slot_valid(slot_valid), .slot_is_mask(slot_is_mask), .slot_mbit(slot_mbit),
    .slot_mask_a(slot_mask_a), .slot_mask_b(slot_mask_b),
    .slot_xop(slot_xop), .slot_xbank(slot_xbank)
  );

  typedef struct {
    int         due;
    bit         is_mask;
    logic [15:0] be;
    string      req;
  } exp_t;

  exp_t sb[$];
  exp_t cur;
  int   cyc = 0;
  int   n_chk = 0, n_fail = 0;
  int   exp_dly = 1;
  bit   mon_on = 0;
  bit   finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, string what, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, expv, cyc);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // Monitor: compares each emitted slot with the scoreboard front.
  always @(negedge clk) begin
    if (mon_on) begin
      if (sb.size() > 0 && sb[0].due == cyc) begin
        cur = sb.pop_front();
        chk(slot_valid == 1'b1, cur.req, "slot_valid (R8)", slot_valid, 1);
        chk(slot_is_mask == cur.is_mask, cur.req, "slot_is_mask", slot_is_mask, cur.is_mask);
        chk(slot_mbit == cur.is_mask, cur.req, "slot_mbit", slot_mbit, cur.is_mask);
        if (cur.is_mask) begin
          chk(slot_mask_a == cur.be[7:0], "R3", "mask_a", slot_mask_a, cur.be[7:0]);
          chk(slot_mask_b == cur.be[15:8], "R3", "mask_b", slot_mask_b, cur.be[15:8]);
          chk(pre_ack == 1'b0, "R6", "pre_ack on mask slot", pre_ack, 0);
        end else begin
          chk({slot_mask_b, slot_mask_a} == 16'h0, "R4", "ext masks", {slot_mask_b, slot_mask_a}, 0);
          if (pre_req) begin
            chk(slot_xop == 2'b01, "R6", "xop", slot_xop, 1);
            chk(slot_xbank == pre_bank, "R6", "xbank", slot_xbank, pre_bank);
            chk(pre_ack == 1'b1, "R6", "pre_ack", pre_ack, 1);
          end else begin
            chk(slot_xop == 2'b00, "R7", "xop", slot_xop, 0);
            chk(slot_xbank == '0, "R7", "xbank", slot_xbank, 0);
            chk(pre_ack == 1'b0, "R7", "pre_ack", pre_ack, 0);
          end
        end
      end else begin
        if (sb.size() > 0 && sb[0].due < cyc) begin
          chk(0, "R8", "slot missed at due cycle", 0, sb[0].due);
          void'(sb.pop_front());
        end
        chk(slot_valid == 1'b0, "R10", "stray slot_valid", slot_valid, 0);
      end
    end
  end

  // Driver: presents one command, waits for acceptance, records expectation.
  task automatic issue(bit wr, logic [15:0] be, string req);
    exp_t e;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_is_write = wr; cmd_be = be;
    #1;
    while (!cmd_ready) begin
      @(negedge clk);
      #1;
    end
    e.due = cyc + exp_dly;
    e.is_mask = wr && (be != 16'hFFFF);
    e.be = be;
    e.req = req;
    sb.push_back(e);
    @(posedge clk);
  endtask

  task automatic idle(int n);
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic set_delay(int v);
    @(negedge clk);
    cfg_delay = DLY_W'(v);
    exp_dly = (v == 0) ? 1 : (v > MAX_DLY ? MAX_DLY : v);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "ALL", "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    rst_n = 1'b0; cfg_delay = 1; cmd_valid = 0; cmd_is_write = 0;
    cmd_be = 0; pre_req = 0; pre_bank = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    chk(slot_valid == 0, "R1", "slot_valid after reset", slot_valid, 0);
    chk(cmd_ready == 1, "R1", "cmd_ready after reset", cmd_ready, 1);
    mon_on = 1;

    // R4 / R7: full writes, no precharge pending
    issue(1, 16'hFFFF, "R4");
    idle(2);
    // R2 / R3: all-zeros and single-hole partial writes
    issue(1, 16'h0000, "R2");
    issue(1, 16'hFFFE, "R2");
    issue(1, 16'h7FFF, "R2");
    idle(2);
    // R5 / R6: reads with partial enables and a precharge pending
    pre_req = 1; pre_bank = 5'h13;
    issue(0, 16'h00F0, "R5");
    issue(0, 16'hFFFF, "R5");
    issue(1, 16'h1234, "R6");
    issue(1, 16'hFFFF, "R6");
    idle(2);
    pre_req = 0;
    // R11: back-to-back random traffic
    for (int i = 0; i < 40; i++) begin
      if (i % 7 == 3) begin pre_req = 1; pre_bank = BANK_W'($urandom); end
      else pre_req = 0;
      issue(($urandom % 4) != 0, (i % 5 == 0) ? 16'hFFFF : 16'($urandom), "R11");
    end
    idle(3);
    pre_req = 0;

    // R9: change delay while a slot is in flight
    issue(1, 16'hAAAA, "R9");
    @(negedge clk);
    cmd_valid = 0;
    cfg_delay = 3;
    #1;
    chk(cmd_ready == 0, "R9", "cmd_ready while delay change pending", cmd_ready, 0);
    exp_dly = 3;
    for (int i = 0; i < 10; i++) issue(i[0], 16'($urandom), "R8");
    idle(6);

    // R8: clamp of 0 and of values above the maximum
    set_delay(0);
    for (int i = 0; i < 6; i++) issue(1, 16'($urandom), "R8");
    idle(3);
    set_delay(15);
    for (int i = 0; i < 6; i++) issue(i < 3, 16'($urandom), "R8");
    idle(MAX_DLY + 4);
    set_delay(2);
    pre_req = 1; pre_bank = 5'h07;
    issue(0, 16'h0001, "R5");
    issue(1, 16'hFFFF, "R6");
    idle(6);

    chk(sb.size() == 0, "R10", "scoreboard drained", sb.size(), 0);
    summary();
  end
endmodule